// File: doc/BRIEF.md
# Multi-Rail Reset Supervisor

This block turns digitized supply-monitor comparator flags into system reset and warning outputs. It watches one main rail and two secondary rails. The analog comparators and their thresholds sit outside it and reach it only as asynchronous digital flags. It also takes a raw manual reset pin, which it debounces. A two-bit code chooses one of four power-on timeouts.

The main rail drives a reset that is held through the power-on timeout after every recovery. The same rail also drives an early low-line warning that follows the rail with no delay. Each secondary rail has its own latched fail output. It sets on the below-trip flag and clears only on a separate above-hysteresis flag. A per-rail merge bit either folds the fail into reset or leaves it as a stand-alone power-fail interrupt.

Top module: `rail_reset_supervisor`

## Requirements
- R1: When `main_low_a` goes high, `reset` goes to 1 and `reset_n` to 0 exactly two clock edges later (synchronizer latency).
- R2: Once every reset cause is clear, `reset` stays asserted and falls on the (T+2)-th edge after the last cause cleared, where T is the selected timeout in cycles.
- R3: `por_sel` code 0 gives T = POR_BASE, 1 gives 4*POR_BASE, 2 gives 16*POR_BASE and 3 gives 64*POR_BASE cycles.
- R4: `lowline_n` is the inverse of the synchronized main-rail flag. It falls two edges after `main_low_a` rises and rises two edges after it falls, with no timeout applied.
- R5: Bit i of `sec_fail` sets three edges after `sec_low_a[i]` is high. It clears only when `sec_ok_a[i]` is high and `sec_low_a[i]` is low. When both flags are low it holds its value, and when both are high the below-trip flag wins.
- R6: With `sec_merge[i]`=1, `sec_fail[i]` is ORed directly into `reset` and does not restart the timeout. With `sec_merge[i]`=0 it has no effect on `reset`.
- R7: `mr_n_a` (active low) must hold a new level for DB_CYCLES clocks before it counts. A press asserts `reset` DB_CYCLES+2 edges after the pin falls, and a low pulse of DB_CYCLES-2 clocks has no effect on `reset`.
- R8: Releasing a debounced manual reset restarts the full timeout, so `reset` falls DB_CYCLES+2+T edges after the pin returns high.
- R9: While `rst_n` is low, `reset`=1, `reset_n`=0, `lowline_n`=0 and `sec_fail` is all ones. After `rst_n` rises with good rails, `reset` falls on edge T+2.
- R10: `reset_n` is the exact complement of `reset` on every cycle.
- R11: `supply_ok_a` low asserts `reset` two edges later and restarts the timeout, and it leaves `lowline_n` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| main_low_a | input | 1 | Main rail below its trip point (asynchronous) |
| supply_ok_a | input | 1 | Supply high enough for valid operation (asynchronous) |
| sec_low_a | input | NSEC | Secondary rail below its trip point (asynchronous) |
| sec_ok_a | input | NSEC | Secondary rail above trip plus hysteresis (asynchronous) |
| mr_n_a | input | 1 | Raw manual reset pin, active low |
| por_sel | input | 2 | Power-on timeout select |
| sec_merge | input | NSEC | 1 = fold the secondary fail into reset |
| reset_n | output | 1 | System reset, active low |
| reset | output | 1 | System reset, active high |
| lowline_n | output | 1 | Early main-rail warning, active low |
| sec_fail | output | NSEC | Secondary rail fail flags |

## Verification
The bench counts the exact edge of each reset release for all four timeout codes, and after a manual reset release. A design that skipped the restart, or counted one register too few or too many, would release early or late. A table walks the secondary flags through the hysteresis band, the case where both flags are high, and merge changes. A latch that cleared on a missing below-trip flag, or let the recovery flag win, would show the wrong fail bit. A short manual pulse and a supply-valid drop check that a glitch never reaches reset and that the warning output stays out of the timeout path.

// File: rtl/rsup_pkg.sv
// Shared helpers for the reset supervisor.
// Assumes the timeout select is two bits wide.
package rsup_pkg;
    // Timeout length in cycles for a select code: base scaled by 4^sel.
    function automatic int unsigned por_cycles(input int unsigned base, input logic [1:0] sel);
        return base << (2 * sel);
    endfunction
endpackage

// File: rtl/rsup_sync.sv
// Two-flop synchronizer bank for asynchronous comparator flags.
// Assumes each bit is independent. RST_VAL gives each bit its reset (safe) level.
module rsup_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_a,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages; both load the safe value in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d_a;
            q    <= meta;
        end
    end
endmodule

// File: rtl/rsup_debounce.sv
// Debouncer: the output takes a new input level only after the input has held
// that level for DB_CYCLES consecutive clocks. Assumes the input is already synchronous.
module rsup_debounce #(
    parameter int DB_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(DB_CYCLES) + 1;
    logic [CW-1:0] run;

    // Count the cycles in which the input differs from the output; flip when the count is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean <= 1'b0;
            run   <= '0;
        end else if (raw != clean) begin
            if (run == CW'(DB_CYCLES - 1)) begin
                clean <= raw;
                run   <= '0;
            end else begin
                run <= run + 1'b1;
            end
        end else begin
            run <= '0;
        end
    end

    // A change of the output must match the input level seen on the edge before.
    assert_flip_matches_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clean != $past(clean)) |-> ($past(raw) == clean));
endmodule

// File: rtl/rsup_por_timer.sv
// Power-on timeout: holds 'hold' high until 'clear' has been low for the
// selected number of cycles. Assumes por_sel changes only while clear is high.
module rsup_por_timer #(
    parameter int POR_BASE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic [1:0] por_sel,
    output logic       hold
);
    import rsup_pkg::*;
    localparam int MAXC = POR_BASE * 64;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    // Decode the select code into a cycle count.
    always_comb limit = CW'(por_cycles(POR_BASE, por_sel));

    // Clear on any cause; otherwise count up to the limit and stop.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (cnt < limit) cnt <= cnt + 1'b1;
    end

    // Hold until the count reaches the selected limit.
    always_comb hold = (cnt < limit);

    // Release may only follow a cycle in which no cause was present.
    assert_release_needs_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold) |-> !$past(clear));
    // Counter never passes the largest timeout.
    assert_cnt_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(MAXC));
endmodule

// File: rtl/rsup_rail_latch.sv
// Fail latch for one secondary rail: set by the below-trip flag, cleared only by the
// above-hysteresis flag. Below-trip wins if both are seen. Resets to failed.
module rsup_rail_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic low,
    input  logic ok,
    output logic fail
);
    // Set/clear latch with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)   fail <= 1'b1;
        else if (low) fail <= 1'b1;
        else if (ok)  fail <= 1'b0;
    end

    // A below-trip flag always leaves the latch set.
    assert_low_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(low) |-> fail);
    // A clear needs the recovery flag and no below-trip flag.
    assert_clear_needs_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fail) |-> ($past(ok) && !$past(low)));
endmodule

// File: rtl/rail_reset_supervisor.sv
// Multi-rail reset supervisor. It synchronizes the comparator flags, debounces the
// manual pin, times the power-on hold and latches the secondary rail fails.
// Assumes: flags are asynchronous and level-valid; sec_merge and por_sel are quasi-static.
module rail_reset_supervisor #(
    parameter int NSEC      = 2,
    parameter int POR_BASE  = 16,
    parameter int DB_CYCLES = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            main_low_a,
    input  logic            supply_ok_a,
    input  logic [NSEC-1:0] sec_low_a,
    input  logic [NSEC-1:0] sec_ok_a,
    input  logic            mr_n_a,
    input  logic [1:0]      por_sel,
    input  logic [NSEC-1:0] sec_merge,
    output logic            reset_n,
    output logic            reset,
    output logic            lowline_n,
    output logic [NSEC-1:0] sec_fail
);
    localparam int SW = 3 + 2 * NSEC;
    // Safe reset levels: main low, supply bad, secondaries low/not ok, manual released.
    localparam logic [SW-1:0] SAFE = {1'b1, 1'b0, {NSEC{1'b1}}, {NSEC{1'b0}}, 1'b1};

    logic [SW-1:0]   sync_q;
    logic            main_low_s, supply_ok_s, mr_n_s;
    logic [NSEC-1:0] sec_low_s, sec_ok_s;
    logic            mr_act, por_clear, por_hold, merged;

    rsup_sync #(.W(SW), .RST_VAL(SAFE)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_a({main_low_a, supply_ok_a, sec_low_a, sec_ok_a, mr_n_a}),
        .q(sync_q)
    );

    // Split the synchronized bundle back into named flags.
    always_comb {main_low_s, supply_ok_s, sec_low_s, sec_ok_s, mr_n_s} = sync_q;

    rsup_debounce #(.DB_CYCLES(DB_CYCLES)) u_db (
        .clk(clk), .rst_n(rst_n), .raw(!mr_n_s), .clean(mr_act)
    );

    // Any cause that must restart the power-on timeout.
    always_comb por_clear = main_low_s | !supply_ok_s | mr_act;

    rsup_por_timer #(.POR_BASE(POR_BASE)) u_por (
        .clk(clk), .rst_n(rst_n), .clear(por_clear), .por_sel(por_sel), .hold(por_hold)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NSEC; gi++) begin : g_sec
            rsup_rail_latch u_latch (
                .clk(clk), .rst_n(rst_n),
                .low(sec_low_s[gi]), .ok(sec_ok_s[gi]), .fail(sec_fail[gi])
            );
        end
    endgenerate

    // Secondary fails routed into reset by their merge bits.
    always_comb merged = |(sec_fail & sec_merge);

    // Reset is the timer hold or any direct cause; the low-line warning follows the main rail alone.
    always_comb begin
        reset     = por_clear | por_hold | merged;
        reset_n   = !reset;
        lowline_n = !main_low_s;
    end

    // A synchronized main-rail low always shows on reset.
    assert_main_low_resets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        main_low_s |-> reset);
    // Reset may only fall when the warning output is high.
    assert_release_with_line_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reset) |-> lowline_n);
endmodule

// File: tb/sim_rail_reset_supervisor.sv
module sim_rail_reset_supervisor;
    localparam int NSEC = 2, BASE = 16, DB = 8;

    logic clk = 0, rst_n = 0, main_low_a = 0, supply_ok_a = 1, mr_n_a = 1;
    logic [NSEC-1:0] sec_low_a = '0, sec_ok_a = '1, sec_merge = '0;
    logic [1:0] por_sel = 0;
    logic reset_n, reset, lowline_n;
    logic [NSEC-1:0] sec_fail;
    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    rail_reset_supervisor #(.NSEC(NSEC), .POR_BASE(BASE), .DB_CYCLES(DB)) u0 (
        .clk(clk), .rst_n(rst_n), .main_low_a(main_low_a), .supply_ok_a(supply_ok_a),
        .sec_low_a(sec_low_a), .sec_ok_a(sec_ok_a), .mr_n_a(mr_n_a), .por_sel(por_sel),
        .sec_merge(sec_merge), .reset_n(reset_n), .reset(reset), .lowline_n(lowline_n),
        .sec_fail(sec_fail));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count edges until reset reaches val (sampled at negedge), up to lim.
    task automatic edges_until(input logic val, input int lim, output int n);
        n = 0;
        do begin
            @(negedge clk); n++;
            chk("R10 complement", reset_n, !reset);
        end while (reset != val && n < lim);
    endtask

    task automatic step(input int k);
        repeat (k) @(negedge clk);
    endtask

    // Vector: low, ok, merge, expected fail, expected reset
    typedef struct packed {
        logic [1:0] low; logic [1:0] ok; logic [1:0] mg; logic [1:0] ef; logic er;
    } vec_t;
    localparam vec_t VT [10] = '{
        '{2'b00, 2'b11, 2'b00, 2'b00, 1'b0},
        '{2'b01, 2'b11, 2'b00, 2'b01, 1'b0},
        '{2'b00, 2'b00, 2'b00, 2'b01, 1'b0},
        '{2'b00, 2'b01, 2'b01, 2'b00, 1'b0},
        '{2'b10, 2'b00, 2'b01, 2'b10, 1'b0},
        '{2'b10, 2'b00, 2'b10, 2'b10, 1'b1},
        '{2'b00, 2'b00, 2'b10, 2'b10, 1'b1},
        '{2'b00, 2'b10, 2'b10, 2'b00, 1'b0},
        '{2'b11, 2'b00, 2'b11, 2'b11, 1'b1},
        '{2'b00, 2'b11, 2'b11, 2'b00, 1'b0}
    };

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n;
        step(3);
        // R9 reset state
        chk("R9 reset", reset, 1);
        chk("R9 reset_n", reset_n, 0);
        chk("R9 lowline_n", lowline_n, 0);
        chk("R9 sec_fail", sec_fail, 2'b11);
        rst_n = 1;
        edges_until(0, 100, n);
        chk("R9 power-on release edge", n, BASE + 2);
        chk("R4 lowline high", lowline_n, 1);

        // Secondary table (R5, R6)
        foreach (VT[i]) begin
            sec_low_a = VT[i].low; sec_ok_a = VT[i].ok; sec_merge = VT[i].mg;
            step(4);
            chk($sformatf("R5 vec%0d sec_fail", i), sec_fail, VT[i].ef);
            chk($sformatf("R6 vec%0d reset", i), reset, VT[i].er);
            chk("R10 complement", reset_n, !reset);
        end
        sec_merge = 0;

        // R1/R4/R2/R3 main rail dips, each timeout code
        for (int s = 0; s < 4; s++) begin
            main_low_a = 1;
            step(1);
            chk("R1 not before 2 edges", reset, 0);
            step(1);
            chk("R1 reset after 2 edges", reset, 1);
            chk("R4 lowline low", lowline_n, 0);
            por_sel = 2'(s);
            step(2);
            main_low_a = 0;
            step(2);
            chk("R4 lowline immediate", lowline_n, 1);
            chk("R2 still held", reset, 1);
            edges_until(0, 2000, n);
            chk($sformatf("R3 sel%0d release edge", s), n + 2, (BASE << (2 * s)) + 2);
        end
        por_sel = 0;

        // R7 short pulse ignored
        mr_n_a = 0; step(DB - 2); mr_n_a = 1;
        edges_until(1, 30, n);
        chk("R7 glitch ignored", reset, 0);

        // R7 press latency, R8 release restart
        mr_n_a = 0;
        step(DB + 1);
        chk("R7 not yet", reset, 0);
        step(1);
        chk("R7 press asserts", reset, 1);
        step(10);
        mr_n_a = 1;
        edges_until(0, 200, n);
        chk("R8 release edge", n, DB + 2 + BASE);

        // R11 supply valid
        supply_ok_a = 0;
        step(2);
        chk("R11 reset", reset, 1);
        chk("R11 lowline unchanged", lowline_n, 1);
        supply_ok_a = 1;
        edges_until(0, 200, n);
        chk("R11 restart edge", n, BASE + 2);

        finish_run();
    end
endmodule